// File: doc/BRIEF.md
# Multiprocessor-Mode Serial Transmitter

This block is an asynchronous serial transmitter for networks in which one sender addresses many receivers. Every frame carries one extra bit after the data byte. A 1 in that bit marks the frame as an ID (address) frame, and a 0 marks it as a data frame. Software reaches the block through a small register port. The port holds a control register with a transmit-on bit, a one-byte data holding register, a status register and a baud divisor. The status register holds a holding-register-empty flag, a transmission-finished flag and the extra bit that goes with the next frame.

A byte is handed over in three steps. Software reads the status register and sees the empty flag at 1, writes the byte, then writes the status register with bit 0 at 0. Writing bit 0 at 0 clears the flag and releases the byte for transmission. A DMA-style controller can instead answer the empty request with a single write on its own strobe, and that write also clears the flag. When transmit is switched on, the line first carries one frame of all ones. After that, each frame is taken from the holding register as soon as the previous frame ends. While transmit is off, the pin follows a port override, which allows a break (a steady 0) to be sent after the last frame.

Top module: `mptx_top`

## Requirements
- R1: After reset, txd is 1, txi_req and tei_req are 0, bus_rdata is 0, and the control register (address 0) reads 0.
- R2: When the transmit-on bit (address 0, bit 0) changes from 0 to 1, the line first carries 11 bit times of 1. Data that is already pending waits until this idle frame has ended.
- R3: A frame is 11 bits, each lasting 16*(D+1) clock cycles, where D is the baud divisor at address 3. The bits are sent in this order: a start bit of 0, then the 8 data bits with the LSB first, then the extra bit, then a stop bit of 1.
- R4: A status write (address 2) with bit 0 at 0 clears the empty flag (status bit 0) only when the status register was read with the empty flag at 1 after the last status write. Any other status write leaves the empty flag unchanged.
- R5: The extra bit of a frame equals status bit 2 at the moment the frame is taken from the holding register. Status bit 2 is written through address 2.
- R6: When a frame is taken from the holding register, the empty flag becomes 1 and the finished flag (status bit 1) becomes 0. If a byte is already pending when a frame ends, its start bit follows the previous stop bit with no gap.
- R7: When a frame ends and no byte is pending, the finished flag becomes 1 and the line stays at 1.
- R8: txi_req equals (transmit-on AND empty flag), and tei_req equals (transmit-on AND finished flag). Each is registered one cycle behind the flags.
- R9: A pulse on dma_we writes dma_wdata into the holding register and clears the empty flag without the read-then-clear sequence.
- R10: While transmit is off, txd follows pin_val when pin_dir is 1 and is 1 when pin_dir is 0. Both flags read 1. Switching transmit off in the middle of a frame hands the pin to the override on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register select: 0 control, 1 data, 2 status, 3 divisor |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Registered read data, valid one cycle after bus_re |
| dma_we | input | 1 | DMA-style write to the holding register |
| dma_wdata | input | 8 | Data for dma_we |
| pin_dir | input | 1 | Port override drives the pin while transmit is off |
| pin_val | input | 1 | Port override level |
| txd | output | 1 | Serial line |
| txi_req | output | 1 | Holding register empty request |
| tei_req | output | 1 | Transmission finished request |

## Verification
The timing of each result is counted from the register edge on which the stimulus takes effect. Read data, txi_req and tei_req appear one cycle after their source. A byte released on an idle line is taken one cycle after the clear, and its start bit reaches txd one cycle after that. After transmit is switched on, the idle frame starts two cycles after the control write. The bench model advances its own cycle counts on each rising edge, and all comparisons happen on the falling edge, so every result is compared in the cycle it is due. Frame contents are also checked by a separate decoder. The decoder samples txd at the middle of each bit, counting from the start-bit edge.

// File: rtl/mptx_pkg.sv
package mptx_pkg;
  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_DATA = 2'd1,
    REG_STAT = 2'd2,
    REG_BAUD = 2'd3
  } reg_sel_e;

  localparam int CTRL_TXON = 0;
  localparam int ST_EMPTY  = 0;
  localparam int ST_DONE   = 1;
  localparam int ST_MPB    = 2;
endpackage

// File: rtl/mptx_regs.sv
module mptx_regs
  import mptx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              dma_we,
  input  logic [DATA_W-1:0] dma_wdata,
  input  logic              load_pulse,
  input  logic              done_pulse,
  output logic              tx_on,
  output logic [DATA_W-1:0] data_q,
  output logic              mpb_q,
  output logic              empty_q,
  output logic [DATA_W-1:0] div_q,
  output logic              txi_req,
  output logic              tei_req
);
  logic done_q;
  logic arm_q;
  logic stat_wr;
  logic stat_rd;
  logic [DATA_W-1:0] rd_mux;

  assign stat_wr = bus_we && (bus_addr == REG_STAT);
  assign stat_rd = bus_re && (bus_addr == REG_STAT);

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      REG_CTRL: rd_mux[CTRL_TXON] = tx_on;
      REG_DATA: rd_mux = data_q;
      REG_STAT: begin
        rd_mux[ST_EMPTY] = empty_q;
        rd_mux[ST_DONE]  = done_q;
        rd_mux[ST_MPB]   = mpb_q;
      end
      default:  rd_mux = div_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_on     <= 1'b0;
      data_q    <= '0;
      mpb_q     <= 1'b0;
      div_q     <= '0;
      empty_q   <= 1'b1;
      done_q    <= 1'b1;
      arm_q     <= 1'b0;
      txi_req   <= 1'b0;
      tei_req   <= 1'b0;
      bus_rdata <= '0;
    end else begin
      if (bus_we && (bus_addr == REG_CTRL)) tx_on  <= bus_wdata[CTRL_TXON];
      if (bus_we && (bus_addr == REG_DATA)) data_q <= bus_wdata;
      if (bus_we && (bus_addr == REG_BAUD)) div_q  <= bus_wdata;
      if (stat_wr) mpb_q <= bus_wdata[ST_MPB];
      if (dma_we) data_q <= dma_wdata;

      if (!tx_on) begin
        empty_q <= 1'b1;
        done_q  <= 1'b1;
        arm_q   <= 1'b0;
      end else begin
        if (stat_rd && empty_q) arm_q <= 1'b1;
        if (stat_wr || dma_we) arm_q <= 1'b0;
        if (stat_wr && !bus_wdata[ST_EMPTY] && arm_q && empty_q) empty_q <= 1'b0;
        if (dma_we) empty_q <= 1'b0;
        if (load_pulse) begin
          empty_q <= 1'b1;
          done_q  <= 1'b0;
        end
        if (done_pulse) done_q <= 1'b1;
      end

      txi_req <= tx_on && empty_q;
      tei_req <= tx_on && done_q;
      if (bus_re) bus_rdata <= rd_mux;
    end
  end

  // R4
  ignored_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_on && stat_wr && !arm_q && empty_q && !dma_we) |=> empty_q);

  // R6
  load_flags_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_on && load_pulse) |=> (empty_q && !done_q));

  // R8
  txi_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_on && empty_q) |=> txi_req);

  // R9
  dma_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_on && dma_we && !load_pulse) |=> !empty_q);

  // R10
  off_flags_chk: assert property (@(posedge clk) disable iff (rst)
    !tx_on |=> (empty_q && done_q));
endmodule

// File: rtl/mptx_baud.sv
module mptx_baud #(
  parameter int DIV_W = 8,
  parameter int OVS   = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             restart,
  input  logic [DIV_W-1:0] div,
  output logic             strobe
);
  localparam int SUB_W = (OVS > 1) ? $clog2(OVS) : 1;

  logic [DIV_W-1:0] pre_q;
  logic [SUB_W-1:0] sub_q;
  logic pre_end;
  logic sub_end;

  assign pre_end = (pre_q >= div);
  assign sub_end = (sub_q == SUB_W'(OVS - 1));
  assign strobe  = pre_end && sub_end;

  always_ff @(posedge clk) begin
    if (rst || !run || restart) begin
      pre_q <= '0;
      sub_q <= '0;
    end else if (pre_end) begin
      pre_q <= '0;
      sub_q <= sub_end ? '0 : sub_q + 1'b1;
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end
endmodule

// File: rtl/mptx_shift.sv
module mptx_shift #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_on,
  input  logic              strobe,
  input  logic              empty,
  input  logic [DATA_W-1:0] data,
  input  logic              mpb,
  input  logic              pin_dir,
  input  logic              pin_val,
  output logic              restart,
  output logic              load_pulse,
  output logic              done_pulse,
  output logic              txd
);
  localparam int FRAME_W = DATA_W + 3;
  localparam int CNT_W   = $clog2(FRAME_W);

  logic               on_q;
  logic               busy;
  logic [FRAME_W-1:0] sh;
  logic [CNT_W-1:0]   bitc;
  logic               txd_q;
  logic               rise;
  logic               last;
  logic [FRAME_W-1:0] frame_word;

  assign frame_word = {1'b1, mpb, data, 1'b0};
  assign rise       = tx_on && !on_q;
  assign last       = (bitc == CNT_W'(FRAME_W - 1));
  assign load_pulse = tx_on && !rise && !empty && (!busy || (strobe && last));
  assign done_pulse = tx_on && !rise && busy && strobe && last && empty;
  assign restart    = rise || load_pulse;
  assign txd        = txd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      on_q  <= 1'b0;
      busy  <= 1'b0;
      sh    <= '1;
      bitc  <= '0;
      txd_q <= 1'b1;
    end else begin
      on_q  <= tx_on;
      txd_q <= tx_on ? sh[0] : (pin_dir ? pin_val : 1'b1);
      if (!tx_on) begin
        busy <= 1'b0;
        sh   <= '1;
        bitc <= '0;
      end else if (rise) begin
        busy <= 1'b1;
        sh   <= '1;
        bitc <= '0;
      end else if (load_pulse) begin
        busy <= 1'b1;
        sh   <= frame_word;
        bitc <= '0;
      end else if (done_pulse) begin
        busy <= 1'b0;
      end else if (busy && strobe) begin
        sh   <= {1'b1, sh[FRAME_W-1:1]};
        bitc <= bitc + 1'b1;
      end
    end
  end

  // R2
  idle_frame_chk: assert property (@(posedge clk) disable iff (rst)
    rise |=> (busy && (&sh)));

  // R3
  start_bit_chk: assert property (@(posedge clk) disable iff (rst)
    (load_pulse ##1 tx_on) |=> (txd_q == 1'b0));

  // R7
  idle_line_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_on && !busy) |=> txd_q);
endmodule

// File: rtl/mptx_top.sv
module mptx_top #(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              dma_we,
  input  logic [DATA_W-1:0] dma_wdata,
  input  logic              pin_dir,
  input  logic              pin_val,
  output logic              txd,
  output logic              txi_req,
  output logic              tei_req
);
  logic              tx_on;
  logic [DATA_W-1:0] data_q;
  logic              mpb_q;
  logic              empty_q;
  logic [DATA_W-1:0] div_q;
  logic              load_pulse;
  logic              done_pulse;
  logic              restart;
  logic              strobe;

  mptx_regs #(.DATA_W(DATA_W)) regs_i (
    .clk, .rst, .bus_we, .bus_re, .bus_addr, .bus_wdata, .bus_rdata,
    .dma_we, .dma_wdata, .load_pulse, .done_pulse, .tx_on, .data_q,
    .mpb_q, .empty_q, .div_q, .txi_req, .tei_req
  );

  mptx_baud #(.DIV_W(DATA_W), .OVS(OVS)) baud_i (
    .clk, .rst, .run(tx_on), .restart, .div(div_q), .strobe
  );

  mptx_shift #(.DATA_W(DATA_W)) shift_i (
    .clk, .rst, .tx_on, .strobe, .empty(empty_q), .data(data_q),
    .mpb(mpb_q), .pin_dir, .pin_val, .restart, .load_pulse, .done_pulse,
    .txd
  );
endmodule

// File: tb/mptx_top_tb_top.sv
module mptx_top_tb_top;
  localparam int OVS = 16;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst = 1'b1, bus_we = 0, bus_re = 0, dma_we = 0, pin_dir = 0, pin_val = 0;
  logic [1:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0, dma_wdata = 0, bus_rdata;
  logic txd, txi_req, tei_req;

  mptx_top dut_i (.clk, .rst, .bus_we, .bus_re, .bus_addr, .bus_wdata, .bus_rdata,
    .dma_we, .dma_wdata, .pin_dir, .pin_val, .txd, .txi_req, .tei_req);

  int nvec = 0, nbad = 0, tper = 32;
  bit finished = 0;
  string req = "R1";

  // behavioural reference: integer counters per cycle
  int m_on, m_dr, m_empty, m_done, m_mp, m_div, m_arm, m_onq, m_busy, m_frame, m_bit, m_ph;
  int m_txd, m_txi, m_tei;

  always @(posedge clk) begin : model
    int t, n_on, n_dr, n_empty, n_done, n_mp, n_div, n_arm, n_busy, n_frame, n_bit, n_ph;
    bit strobe, rise, last, load, fin;
    if (rst) begin
      m_on = 0; m_dr = 0; m_empty = 1; m_done = 1; m_mp = 0; m_div = 0; m_arm = 0;
      m_onq = 0; m_busy = 0; m_frame = 2047; m_bit = 0; m_ph = 0;
      m_txd = 1; m_txi = 0; m_tei = 0;
    end else begin
      t = OVS * (m_div + 1);
      strobe = (m_ph == t - 1);
      rise = (m_on != 0) && (m_onq == 0);
      last = (m_bit == 10);
      load = 0; fin = 0;
      n_busy = m_busy; n_frame = m_frame; n_bit = m_bit;
      if (m_on == 0) begin n_busy = 0; n_bit = 0; n_frame = 2047; end
      else if (rise) begin n_busy = 1; n_frame = 2047; n_bit = 0; end
      else if (m_empty == 0 && (m_busy == 0 || (strobe && last))) begin
        load = 1; n_busy = 1; n_bit = 0;
        n_frame = 1024 | (m_mp << 9) | (m_dr << 1);
      end else if (m_busy != 0 && strobe && last) begin fin = 1; n_busy = 0; end
      else if (m_busy != 0 && strobe) begin n_frame = (m_frame >> 1) | 1024; n_bit = m_bit + 1; end
      n_ph = (m_on == 0 || rise || load || strobe) ? 0 : m_ph + 1;
      n_on = m_on; n_dr = m_dr; n_div = m_div; n_mp = m_mp;
      n_empty = m_empty; n_done = m_done; n_arm = m_arm;
      if (bus_we && bus_addr == 0) n_on = bus_wdata[0];
      if (bus_we && bus_addr == 1) n_dr = bus_wdata;
      if (bus_we && bus_addr == 3) n_div = bus_wdata;
      if (bus_we && bus_addr == 2) n_mp = bus_wdata[2];
      if (dma_we) n_dr = dma_wdata;
      if (m_on == 0) begin n_empty = 1; n_done = 1; n_arm = 0; end
      else begin
        if (bus_re && bus_addr == 2 && m_empty != 0) n_arm = 1;
        if ((bus_we && bus_addr == 2) || dma_we) n_arm = 0;
        if (bus_we && bus_addr == 2 && !bus_wdata[0] && m_arm != 0 && m_empty != 0) n_empty = 0;
        if (dma_we) n_empty = 0;
        if (load) begin n_empty = 1; n_done = 0; end
        if (fin) n_done = 1;
      end
      m_txd = (m_on != 0) ? (m_frame & 1) : (pin_dir ? pin_val : 1);
      m_txi = (m_on != 0 && m_empty != 0) ? 1 : 0;
      m_tei = (m_on != 0 && m_done != 0) ? 1 : 0;
      m_onq = m_on;
      m_on = n_on; m_dr = n_dr; m_div = n_div; m_mp = n_mp; m_empty = n_empty;
      m_done = n_done; m_arm = n_arm; m_busy = n_busy; m_frame = n_frame;
      m_bit = n_bit; m_ph = n_ph;
    end
  end

  task automatic chk(input string r, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s: actual %0d expected %0d", r, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk({req, " txd"}, int'(txd), m_txd);
      chk({req, " txi_req R8"}, int'(txi_req), m_txi);
      chk({req, " tei_req R8"}, int'(tei_req), m_tei);
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    @(negedge clk); bus_re = 1; bus_addr = a;
    @(negedge clk); bus_re = 0; v = int'(bus_rdata);
  endtask

  task automatic send(input logic [7:0] d, input bit mp);
    int s;
    rd(2, s);
    wr(1, d);
    wr(2, {5'b0, mp, 2'b00});
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_tei();
    int k = 0;
    while (!tei_req && k < 20000) begin @(negedge clk); k++; end
  endtask

  task automatic decode(input string r, input int d, input int mp, output int waited);
    int k = 0, bits = 0;
    while (txd && k < 20000) begin @(negedge clk); k++; end
    waited = k;
    wait_cyc(tper / 2);
    chk({r, " start bit"}, int'(txd), 0);
    for (int i = 0; i < 8; i++) begin
      wait_cyc(tper);
      bits = bits | (int'(txd) << i);
    end
    chk({r, " data byte"}, bits, d);
    wait_cyc(tper);
    chk({r, " extra bit R5"}, int'(txd), mp);
    wait_cyc(tper);
    chk({r, " stop bit"}, int'(txd), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1; nbad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    int v, w;
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1
    chk("R1 txd", int'(txd), 1);
    chk("R1 txi_req", int'(txi_req), 0);
    chk("R1 tei_req", int'(tei_req), 0);
    chk("R1 rdata", int'(bus_rdata), 0);
    rd(0, v); chk("R1 ctrl", v, 0);
    rd(2, v); chk("R10 status when off", v, 3);
    // R3 divisor 1 -> 32 cycles per bit
    wr(3, 8'd1); rd(3, v); chk("R3 divisor", v, 1);
    tper = 32;

    req = "R2";
    wr(0, 8'd1);
    send(8'hA5, 1'b1);
    rd(2, v); chk("R4 accepted clear", v, 6);
    decode("R2 R3", 8'hA5, 1, w);
    chk("R2 idle frame first", (w >= 10 * tper) ? 1 : 0, 1);
    rd(2, v); chk("R6 flags after load", v, 5);

    req = "R7";
    wait_tei();
    rd(2, v); chk("R7 finished flag", v, 7);
    chk("R7 line idle", int'(txd), 1);

    req = "R4";
    wr(2, 8'h01);
    wr(2, 8'h00);
    rd(2, v); chk("R4 ignored clear", v, 3);
    wait_cyc(2 * tper);
    chk("R4 line still idle", int'(txd), 1);

    req = "R6";
    fork
      begin
        decode("R6 first", 8'h3C, 0, w);
        decode("R6 second", 8'h96, 1, w);
        chk("R6 no gap", (w <= tper) ? 1 : 0, 1);
      end
      begin
        send(8'h3C, 1'b0);
        wait_cyc(3);
        send(8'h96, 1'b1);
      end
    join

    req = "R9";
    wait_tei();
    chk("R8 txi when empty", int'(txi_req), 1);
    @(negedge clk); dma_we = 1; dma_wdata = 8'h5A;
    @(negedge clk); dma_we = 0;
    @(negedge clk);
    chk("R8 txi low one cycle", int'(txi_req), 0);
    decode("R9 dma frame", 8'h5A, 1, w);

    req = "R10";
    wait_tei();
    pin_dir = 1; pin_val = 0;
    wr(0, 8'd0);
    wait_cyc(2);
    chk("R10 break", int'(txd), 0);
    rd(2, v); chk("R10 flags off", v, 7);
    pin_val = 1; wait_cyc(2);
    chk("R10 override high", int'(txd), 1);
    pin_dir = 0; pin_val = 0; wait_cyc(2);
    chk("R10 released", int'(txd), 1);
    wr(0, 8'd1);
    send(8'hC3, 1'b0);
    w = 0;
    while (txd && w < 20000) begin @(negedge clk); w++; end
    wait_cyc(40);
    pin_dir = 1; pin_val = 0;
    wr(0, 8'd0);
    wait_cyc(3);
    chk("R10 abort mid-frame", int'(txd), 0);
    rd(2, v); chk("R10 flags after abort", v & 3, 3);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule